// File: doc/BRIEF.md
# Differential PSK Symbol Encoder with Barker Spreading

This block sits after the scrambler in a direct-sequence transmitter. It accepts a serial stream of scrambled bits, each tagged with its rate. From them it builds I/Q chip signs at the chip clock for the 1 Mbps and 2 Mbps modes.

A bit tagged for 1 Mbps is one DBPSK symbol. A bit tagged for 2 Mbps is paired with the bit that follows it to form one DQPSK symbol. Each symbol advances a quadrant accumulator by a phase step. The quadrant sets the signs of the I and Q symbol values, and each symbol is then spread over eleven chips by the Barker word.

The accumulator keeps its value when the stream changes from DBPSK to DQPSK in the middle of a burst. This lets a DBPSK preamble flow straight into a DQPSK header or payload. A one-cycle `burst_start` pulse prepares the block for a new burst. A static configuration input reverses the direction of rotation for quarter-turn steps.

Top module: `dpsk_barker_tx`

## Requirements
- R1: After reset, `chip_valid`, `chip_i` and `chip_q` are 0, and `bit_ready` is 1 while `burst_start` is low and a 1 Mbps bit (`bit_rate`=0) is offered.
- R2: Each symbol fills exactly 11 consecutive chip clocks with `chip_valid` high. Chip k carries the symbol sign multiplied by Barker chip k, in the order +1,-1,+1,+1,-1,+1,+1,+1,-1,-1,-1, and the first chip is emitted first. On `chip_i`/`chip_q`, a 1 means +1 and a 0 means -1.
- R3: A bit tagged 1 Mbps (`bit_rate`=0) makes one DBPSK symbol. A 0 bit keeps the phase and a 1 bit adds 180 degrees. From the start of a burst, DBPSK symbols give `chip_i` equal to `chip_q`.
- R4: A first bit tagged 2 Mbps (`bit_rate`=1) is d0, and the next accepted bit is d1, whatever its tag. The dibit d0,d1 sets the phase step: 00 gives 0 degrees, 01 gives +90, 11 gives 180, and 10 gives -90.
- R5: The accumulated quadrant sets the symbol signs (I,Q). Quadrant 0 gives (+,+), 90 gives (-,+), 180 gives (-,-) and 270 gives (+,-). The first symbol's step is applied to quadrant 0.
- R6: With `rot_rev`=1, the +90 and -90 steps swap direction. The 0 and 180 degree steps are unchanged.
- R7: The quadrant carries over from DBPSK symbols into the DQPSK symbols that follow them in the same burst.
- R8: A `burst_start` pulse returns the quadrant to 0, stops any symbol in progress, and discards a held d0.
- R9: When the next symbol's bits are offered in time, symbols follow one another with no idle chip. When they are not, `chip_valid` falls in the cycle after the last chip.
- R10: A d0 is accepted at any time while none is held. A 1 Mbps bit or a d1 is accepted only on the last chip of a symbol, or while idle. A d1 starts its symbol on the next chip clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock (11 MHz in service) |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | One-cycle pulse that clears the phase and any held bit |
| rot_rev | input | 1 | Reverse the rotation sense of quarter-turn steps |
| bit_valid | input | 1 | Offered bit is valid |
| bit_data | input | 1 | Scrambled bit value |
| bit_rate | input | 1 | Rate tag: 0 = 1 Mbps DBPSK, 1 = 2 Mbps DQPSK |
| bit_ready | output | 1 | Block takes the offered bit at this clock edge |
| chip_valid | output | 1 | A chip is present on `chip_i`/`chip_q` |
| chip_i | output | 1 | I chip sign (1 = +1, 0 = -1) |
| chip_q | output | 1 | Q chip sign (1 = +1, 0 = -1) |

## Verification
The embedded properties watch, on every clock, that a symbol is never cut short, that the output stops after a last chip when no symbol follows, and that a completed dibit starts its symbol at once. They also watch that a DBPSK step keeps the parity of the quadrant and that a burst pulse clears the phase. Only the bench's scenarios can show the actual dibit-to-phase map under both rotation settings, the quadrant-to-sign map, and the Barker chip order. The same holds for phase continuity across the rate switch, the gapless run of a long stream, and the discard of a held half-dibit.

// File: rtl/dpsk_barker_tx.sv
module dpsk_barker_tx #(
  parameter int SPREAD_LEN = 11,
  parameter logic [SPREAD_LEN-1:0] SPREAD_CODE = 11'b00011101101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_start,
  input  logic rot_rev,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic bit_rate,
  output logic bit_ready,
  output logic chip_valid,
  output logic chip_i,
  output logic chip_q
);

  localparam int CW = (SPREAD_LEN > 2) ? $clog2(SPREAD_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SPREAD_LEN - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [1:0]    phase;
  logic          held;
  logic          held_bit;
  logic [1:0]    step;

  wire at_end    = !active || (cnt == LAST);
  assign bit_ready = !burst_start && (at_end || (!held && bit_rate));

  wire take      = bit_valid && bit_ready;
  wire start_sym = take && (held || !bit_rate);
  wire store_d0  = take && !held && bit_rate;

  always_comb begin
    if (held) begin
      case ({held_bit, bit_data})
        2'b00:   step = 2'd0;
        2'b01:   step = rot_rev ? 2'd3 : 2'd1;
        2'b11:   step = 2'd2;
        default: step = rot_rev ? 2'd1 : 2'd3;
      endcase
    end else begin
      step = {bit_data, 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || burst_start) begin
      active   <= 1'b0;
      cnt      <= '0;
      phase    <= 2'd0;
      held     <= 1'b0;
      held_bit <= 1'b0;
    end else begin
      if (start_sym) begin
        active <= 1'b1;
        cnt    <= '0;
        phase  <= phase + step;
        held   <= 1'b0;
      end else if (active && cnt != LAST) begin
        cnt <= cnt + CW'(1);
      end else begin
        active <= 1'b0;
      end
      if (store_d0) begin
        held     <= 1'b1;
        held_bit <= bit_data;
      end
    end
  end

  wire sym_i = ~(phase[1] ^ phase[0]);
  wire sym_q = ~phase[1];

  assign chip_valid = active;
  assign chip_i = active & ~(sym_i ^ SPREAD_CODE[cnt]);
  assign chip_q = active & ~(sym_q ^ SPREAD_CODE[cnt]);

  // R2
  symbol_not_cut_chk: assert property (@(posedge clk) disable iff (!rst_n || burst_start)
    (active && cnt != LAST) |=> (active && cnt == $past(cnt) + CW'(1)));

  // R9
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n || burst_start)
    (active && cnt == LAST && !(bit_valid && bit_ready && (held || !bit_rate))) |=> !active);

  // R10
  dibit_starts_chk: assert property (@(posedge clk) disable iff (!rst_n || burst_start)
    (bit_valid && bit_ready && held) |=> (active && cnt == '0 && !held));

  // R3
  dbpsk_parity_chk: assert property (@(posedge clk) disable iff (!rst_n || burst_start)
    (bit_valid && bit_ready && !held && !bit_rate) |=> (phase[0] == $past(phase[0])));

  // R8
  burst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (phase == 2'd0 && !held && !active));

endmodule

// File: tb/dpsk_barker_tx_bench.sv
module dpsk_barker_tx_bench;
  localparam logic [10:0] BK = 11'b00011101101;
  // entry: {rate, d0, d1, exp_i, exp_q}
  localparam logic [4:0] TBL [10] = '{
    5'b0_0_0_1_1, 5'b0_1_0_0_0, 5'b0_0_0_0_0, 5'b1_0_1_1_0, 5'b1_1_1_0_1,
    5'b1_1_0_1_1, 5'b1_0_0_1_1, 5'b1_0_1_0_1, 5'b1_1_0_1_1, 5'b1_1_1_0_0};

  logic clk = 0, rst_n = 0, burst_start = 0, rot_rev = 0;
  logic bit_valid = 0, bit_data = 0, bit_rate = 0;
  logic bit_ready, chip_valid, chip_i, chip_q;
  int vecs = 0, bad = 0;
  logic exp_i [64];
  logic exp_q [64];
  int wr = 0, rd = 0, k = 0, nchips = 0;
  logic [10:0] cap_i, cap_q;
  bit done = 0;

  always #10 clk = ~clk;

  dpsk_barker_tx u_dpsk_barker_tx (.clk(clk), .rst_n(rst_n), .burst_start(burst_start),
    .rot_rev(rot_rev), .bit_valid(bit_valid), .bit_data(bit_data), .bit_rate(bit_rate),
    .bit_ready(bit_ready), .chip_valid(chip_valid), .chip_i(chip_i), .chip_q(chip_q));

  function automatic logic [10:0] spread(logic s);
    logic [10:0] r;
    for (int j = 0; j < 11; j++) r[j] = ~(s ^ BK[j]);
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic expect_sym(logic i, logic q);
    exp_i[wr] = i; exp_q[wr] = q; wr++;
  endtask

  task automatic send(logic b, logic r);
    @(negedge clk);
    bit_valid = 1; bit_data = b; bit_rate = r;
    #1;
    while (!bit_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    bit_valid = 0; bit_rate = 0;
  endtask

  task automatic drain();
    while (rd != wr || chip_valid) @(negedge clk);
  endtask

  task automatic pulse_burst();
    @(negedge clk); burst_start = 1;
    @(negedge clk); burst_start = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !burst_start) begin
      if (chip_valid) begin
        cap_i[k] = chip_i; cap_q[k] = chip_q; nchips++;
        if (k == 10) begin
          k = 0;
          if (rd >= wr) chk(0, "R2 unexpected symbol", rd, wr);
          else begin
            // R2 R5: chips equal sign times Barker word
            chk({cap_i, cap_q} == {spread(exp_i[rd]), spread(exp_q[rd])}, "R2/R5 symbol chips",
                {cap_i, cap_q}, {spread(exp_i[rd]), spread(exp_q[rd])});
            if (cap_i != cap_q && exp_i[rd] == exp_q[rd] && rd < 3)
              chk(0, "R3 I differs from Q", cap_i, cap_q);
            rd++;
          end
        end else k++;
      end else if (k != 0) begin
        chk(0, "R2 symbol cut short", k, 11);
        k = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; vecs++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(chip_valid == 0 && chip_i == 0 && chip_q == 0, "R1 outputs idle at reset",
        {chip_valid, chip_i, chip_q}, 0);
    chk(bit_ready == 1, "R1 ready at reset", bit_ready, 1);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(chip_valid == 0 && bit_ready == 1, "R1 idle after reset release",
        {chip_valid, bit_ready}, 2'b01);

    // Table walk: R3 R4 R5 R7 R9
    nchips = 0;
    for (int n = 0; n < 10; n++) begin
      expect_sym(TBL[n][1], TBL[n][0]);
      send(TBL[n][3], TBL[n][4]);
      if (TBL[n][4]) send(TBL[n][2], 1'b1);
    end
    drain();
    // R9: gapless stream and drop after the last chip
    chk(nchips == 110, "R9 chip count of stream", nchips, 110);
    @(negedge clk);
    chk(chip_valid == 0, "R9 idle after last chip", chip_valid, 0);

    // R6: reversed rotation; R8 pulse first
    pulse_burst();
    rot_rev = 1;
    expect_sym(0, 0); send(1, 0);                 // 180 -> q2
    expect_sym(1, 0); send(1, 1); send(0, 1);     // 10 rev +90 -> q3
    expect_sym(0, 1); send(1, 1); send(1, 1);     // 11 -> q1
    expect_sym(1, 1); send(0, 1); send(1, 1);     // 01 rev -90 -> q0
    expect_sym(1, 0); send(0, 1); send(1, 1);     // 01 rev -90 -> q3
    drain();
    chk(rd == 5 + 10, "R6 reversed-rotation symbols seen", rd, 15);
    rot_rev = 0;

    // R8: held d0 discarded and phase cleared by burst pulse
    send(1, 1);
    pulse_burst();
    expect_sym(1, 1); send(0, 0);
    drain();
    chk(rd == 16, "R8 single symbol after burst pulse", rd, 16);

    // R10: d0 taken mid-symbol, d1 only at the last chip
    expect_sym(0, 0); send(1, 0);                 // q2
    @(negedge clk); @(negedge clk);
    bit_valid = 1; bit_data = 1; bit_rate = 1; #1;
    chk(bit_ready == 1, "R10 d0 accepted mid-symbol", bit_ready, 1);
    @(posedge clk); #1; bit_valid = 0;
    @(negedge clk); bit_valid = 1; bit_data = 1; bit_rate = 1; #1;
    chk(bit_ready == 0, "R10 d1 held off mid-symbol", bit_ready, 0);
    bit_valid = 0; bit_rate = 0;
    expect_sym(1, 1);                             // 11 -> q0
    send(1, 1);
    drain();
    chk(rd == 18 && chip_valid == 0, "R10 dibit symbol emitted", rd, 18);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule